// File: doc/BRIEF.md
# DDR Sample Deinterleaver

This block sits behind a 12-bit data converter that sends each sample over six lanes at double data rate, with a data-ready strobe forwarded beside them. Within one strobe period each lane carries two adjacent bits of the sample. The odd-numbered bit comes while the strobe is high and is taken on the falling edge. The even-numbered bit comes while the strobe is low and is taken on the next rising edge. The block puts the two halves back together in bit order and returns each full sample as a single-rate word in the strobe domain.

A separate over-range line is captured with the even half and leaves the block in the same cycle as its sample. Two format inputs give the coding the converter sends and the coding the consumer wants. Each is offset binary or two's complement. When the two differ, the sign bit of the assembled word is inverted. A valid output is high in every strobe cycle that carries a sample built since reset.

Top module: `ddr_deinterleave`

## Requirements
- R1: While `rst_n` is low at a rising strobe edge, `sample_out`, `ovr_out` and `valid_out` are zero after that edge.
- R2: Lane k (k = 0..5, lane 5 the most significant) carries sample bit 2k+1 while the strobe is high, and the block takes it on the falling edge.
- R3: Lane k carries sample bit 2k while the strobe is low, and the block takes it on the following rising edge.
- R4: The assembled sample is on `sample_out` right after the rising edge that takes its even half.
- R5: `ovr_in` is taken on the same rising edge as the even half and appears on `ovr_out` together with that sample. `ovr_out` is never high while `valid_out` is low.
- R6: When `src_twos` equals `out_twos` (0 = offset binary, 1 = two's complement), the sample passes through bit for bit.
- R7: When `src_twos` differs from `out_twos`, bit 11 of the output is inverted and bits 10..0 are unchanged.
- R8: After reset `valid_out` stays low until a falling edge has captured an odd half with reset released. After that it is high at every rising edge.
- R9: Each odd half pairs with the even half that follows it in the same strobe period, never with the even half before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| strobe | input | 1 | Forwarded data-ready strobe; both edges are used |
| rst_n | input | 1 | Active-low reset, synchronous to the strobe |
| lane_in | input | 6 | DDR data lanes, lane 5 most significant |
| ovr_in | input | 1 | Over-range flag from the converter |
| src_twos | input | 1 | Coding sent by the converter (1 = two's complement) |
| out_twos | input | 1 | Coding wanted at the output (1 = two's complement) |
| sample_out | output | 12 | Reassembled sample |
| ovr_out | output | 1 | Over-range flag aligned with `sample_out` |
| valid_out | output | 1 | High when `sample_out` carries an assembled sample |

## Verification
The assertions assume a free-running strobe. They also assume that the lanes hold steady around each edge, and that `ovr_in` and both format inputs are steady at the rising edge that takes the even half. The bench changes the lanes only 2 ns after an edge and changes the format selects only between samples. It releases reset both before and after a falling edge, so that the start-up condition on valid is met in both orders.

// File: rtl/ddr_deint_pkg.sv
package ddr_deint_pkg;
  typedef enum logic {
    CODE_OFFSET = 1'b0,
    CODE_TWOS   = 1'b1
  } code_e;
endpackage

// File: rtl/ddr_fall_capture.sv
module ddr_fall_capture #(
  parameter int LANES = 6
) (
  input  logic             strobe,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_in,
  output logic [LANES-1:0] odd_half,
  output logic             odd_seen
);
  always_ff @(negedge strobe) begin
    if (!rst_n) begin
      odd_half <= '0;
      odd_seen <= 1'b0;
    end else begin
      odd_half <= lane_in;
      odd_seen <= 1'b1;
    end
  end

  // R8
  odd_seen_sticky_chk: assert property (@(negedge strobe) disable iff (!rst_n)
    odd_seen |=> odd_seen);
endmodule

// File: rtl/ddr_rise_merge.sv
module ddr_rise_merge
  import ddr_deint_pkg::*;
#(
  parameter int LANES = 6
) (
  input  logic               strobe,
  input  logic               rst_n,
  input  logic [LANES-1:0]   odd_half,
  input  logic               odd_seen,
  input  logic [LANES-1:0]   even_half,
  input  logic               ovr_in,
  input  logic               src_twos,
  input  logic               out_twos,
  output logic [2*LANES-1:0] sample,
  output logic               ovr,
  output logic               valid
);
  localparam int W = 2 * LANES;

  function automatic logic [W-1:0] weave(input logic [LANES-1:0] hi_bits,
                                         input logic [LANES-1:0] lo_bits);
    logic [W-1:0] r;
    r = '0;
    for (int k = 0; k < LANES; k++) begin
      r[2*k+1] = hi_bits[k];
      r[2*k]   = lo_bits[k];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] recode(input logic [W-1:0] s, input logic flip);
    logic [W-1:0] r;
    r = s;
    r[W-1] = s[W-1] ^ flip;
    return r;
  endfunction

  code_e src_code, dst_code;
  logic  flip_msb;
  assign src_code = code_e'(src_twos);
  assign dst_code = code_e'(out_twos);
  assign flip_msb = (src_code != dst_code);

  always_ff @(posedge strobe) begin
    if (!rst_n) begin
      sample <= '0;
      ovr    <= 1'b0;
      valid  <= 1'b0;
    end else begin
      sample <= odd_seen ? recode(weave(odd_half, even_half), flip_msb) : '0;
      ovr    <= ovr_in & odd_seen;
      valid  <= odd_seen;
    end
  end

  // R1
  idle_zero_chk: assert property (@(posedge strobe) disable iff (!rst_n)
    !valid |-> (sample == '0) && !ovr);
  // R5
  ovr_with_valid_chk: assert property (@(posedge strobe) disable iff (!rst_n)
    ovr |-> valid);
endmodule

// File: rtl/ddr_deinterleave.sv
module ddr_deinterleave #(
  parameter int LANES = 6
) (
  input  logic               strobe,
  input  logic               rst_n,
  input  logic [LANES-1:0]   lane_in,
  input  logic               ovr_in,
  input  logic               src_twos,
  input  logic               out_twos,
  output logic [2*LANES-1:0] sample_out,
  output logic               ovr_out,
  output logic               valid_out
);
  localparam int W = 2 * LANES;

  logic [LANES-1:0] odd_half;
  logic             odd_seen;

  ddr_fall_capture #(.LANES(LANES)) u_fall (
    .strobe  (strobe),
    .rst_n   (rst_n),
    .lane_in (lane_in),
    .odd_half(odd_half),
    .odd_seen(odd_seen)
  );

  ddr_rise_merge #(.LANES(LANES)) u_rise (
    .strobe   (strobe),
    .rst_n    (rst_n),
    .odd_half (odd_half),
    .odd_seen (odd_seen),
    .even_half(lane_in),
    .ovr_in   (ovr_in),
    .src_twos (src_twos),
    .out_twos (out_twos),
    .sample   (sample_out),
    .ovr      (ovr_out),
    .valid    (valid_out)
  );

  function automatic logic [LANES-1:0] odd_positions(input logic [W-1:0] s);
    logic [LANES-1:0] r;
    for (int k = 0; k < LANES; k++) r[k] = s[2*k+1];
    return r;
  endfunction

  logic [LANES-1:0] out_odd;
  assign out_odd = odd_positions(sample_out);

  // R2 R9
  odd_bits_match_chk: assert property (@(posedge strobe) disable iff (!rst_n)
    valid_out |-> out_odd[LANES-2:0] == $past(odd_half[LANES-2:0]));
  // R7
  sign_bit_chk: assert property (@(posedge strobe) disable iff (!rst_n)
    valid_out |-> out_odd[LANES-1] ==
      ($past(odd_half[LANES-1]) ^ ($past(src_twos) != $past(out_twos))));
  // R8
  valid_needs_odd_chk: assert property (@(posedge strobe) disable iff (!rst_n)
    valid_out |-> $past(odd_seen));
endmodule

// File: tb/tb_ddr_deinterleave.sv
`timescale 1ns/1ps
module tb_ddr_deinterleave;
  logic        clk = 1'b1;
  logic        rst_n = 1'b0;
  logic [5:0]  lanes = '0;
  logic        ovr_i = 1'b0, src_t = 1'b0, out_t = 1'b0;
  logic [11:0] smp;
  logic        ovr_o, vld;
  int          errors = 0, checks = 0;
  logic        pend = 1'b0;
  logic [11:0] exp_w;
  logic        exp_o;
  string       exp_tag;

  always #4 clk = ~clk;

  ddr_deinterleave dut (.strobe(clk), .rst_n(rst_n), .lane_in(lanes), .ovr_in(ovr_i),
    .src_twos(src_t), .out_twos(out_t), .sample_out(smp), .ovr_out(ovr_o), .valid_out(vld));

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] expect_word(input logic [11:0] w, input logic s, input logic o);
    return (s == o) ? w : {~w[11], w[10:0]};
  endfunction

  task automatic check_pending();
    if (pend) chk(exp_tag, {vld, ovr_o, smp}, {1'b1, exp_o, exp_w});
    pend = 1'b0;
  endtask

  // strobe high: odd bits, strobe low: even bits
  task automatic step(input logic [11:0] w, input logic o, input string tag);
    @(posedge clk); #1;
    check_pending();
    #1;
    for (int k = 0; k < 6; k++) lanes[k] = w[2*k+1];
    #4;
    for (int k = 0; k < 6; k++) lanes[k] = w[2*k];
    ovr_i = o;
    exp_w = expect_word(w, src_t, out_t);
    exp_o = o;
    exp_tag = tag;
    pend = 1'b1;
  endtask

  task automatic flush();
    @(posedge clk); #1;
    check_pending();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset state", {vld, ovr_o, smp}, 14'h0);
    #4 rst_n = 1'b1;            // released after the falling edge
    @(posedge clk); #1;
    chk("R8 no odd half yet", {13'h0, vld}, 14'h0);
    @(posedge clk); #1;
    chk("R8 valid after odd half", {13'h0, vld}, 14'h1);
  endtask

  task automatic t_patterns(input logic s, input logic o);
    src_t = s; out_t = o;
    step(12'h000, 1'b0, (s == o) ? "R6 0x000" : "R7 0x000");
    step(12'h7FF, 1'b0, (s == o) ? "R6 0x7FF" : "R7 0x7FF");
    step(12'h800, 1'b1, "R5 0x800 with ovr");
    step(12'hFFF, 1'b1, "R5 0xFFF with ovr");
    step(12'h001, 1'b0, "R3 lowest even bit");
    step(12'h002, 1'b0, "R2 lowest odd bit");
    step(12'h400, 1'b0, "R3 top even bit");
    step(12'h123, 1'b0, "R4 mixed word");
    flush();
  endtask

  task automatic t_pairing();
    src_t = 1'b0; out_t = 1'b0;
    step(12'hAAA, 1'b0, "R9 odd ones");
    step(12'h555, 1'b1, "R9 even ones");
    step(12'hAAA, 1'b0, "R9 odd ones again");
    step(12'hC3C, 1'b1, "R9 mixed");
    flush();
  endtask

  task automatic t_early_release();
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 chk("R1 reset again", {vld, ovr_o, smp}, 14'h0);
    rst_n = 1'b1;               // released before the falling edge
    @(posedge clk); #1 chk("R8 valid after early release", {13'h0, vld}, 14'h1);
    src_t = 1'b1; out_t = 1'b0;
    step(12'h5A5, 1'b0, "R7 after restart");
    flush();
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_patterns(1'b0, 1'b0);
    t_patterns(1'b1, 1'b1);
    t_patterns(1'b0, 1'b1);
    t_patterns(1'b1, 1'b0);
    t_pairing();
    t_early_release();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule